// File: doc/BRIEF.md
# Cathode Strip Pattern Finder

The block takes one clock's worth of comparator hits from six detector layers, each layer a vector of half-strip bits, and finds the best track candidate in it. For every key half-strip it lays one wide hit envelope over the layers and counts how many layers have a hit inside it. The key layer contributes only the cell at the key position. Every other layer contributes a window of three adjacent half-strips centred on the key.

Within each layer's window one hit is chosen in a fixed priority order. Candidates are qualified by a per-key enable mask and a programmable layer-count threshold. The best qualified key wins. Only then is the bend-angle code derived from the hits chosen for the winner.

A di-strip mode widens every hit to its half-strip pair, so that coarse cosmic-ray tracks are accepted. The result is registered and appears a fixed three clocks after the hits are presented.

Top module: `strip_pattern_finder`

## Requirements
- R1: Outputs are registered and reflect the inputs (hits, mask, threshold, mode) presented exactly 3 rising clock edges earlier. While rst_ni is low, every output is 0.
- R2: For key k, the layer count is the number of layers with a hit in the envelope. On the key layer (parameter, default layer 3) the envelope is cell k alone. On every other layer it is cells k-1, k and k+1.
- R3: Envelope cells below index 0 or above index 31 count as no hit. Hits never wrap from one edge of the array to the other.
- R4: A key qualifies only if its layer count is at least thresh_i. A thresh_i of 0 acts as 1. With thresh_i=4, a 4-layer track is found and a 3-layer track is not.
- R5: Among qualified keys, the one with the highest layer count wins. When counts tie, the lower key index wins.
- R6: Bit k of key_en_i set to 0 removes key k from selection, whatever its count.
- R7: In each non-key layer the hit chosen for the winner is taken in this priority: the centre cell k, then k-1, then k+1.
- R8: bend_o is a 4-bit two's complement sum over non-key layers of the chosen hit offset. A layer below the key layer adds +1 for k-1 and -1 for k+1. A layer above the key layer adds -1 for k-1 and +1 for k+1. Centre hits add 0.
- R9: When distrip_i is 1, each hit bit at index i is replaced by the OR of bits i and i XOR 1 before envelope matching.
- R10: When no key qualifies, valid_o is 0 and key_o, nhit_o and bend_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hits_i | input | 6x32 | Half-strip hits, hits_i[layer][half-strip] |
| key_en_i | input | 32 | Per-key enable mask |
| thresh_i | input | 3 | Minimum layer count for a candidate |
| distrip_i | input | 1 | Di-strip mode select |
| valid_o | output | 1 | A candidate was found |
| key_o | output | 5 | Winning key half-strip |
| nhit_o | output | 3 | Layer count of the winner |
| bend_o | output | 4 | Bend code, two's complement |

## Verification
The block is driven with several track shapes:
- Straight tracks at interior and edge keys show that the centre key outscores its neighbours.
- A tilted track with left hits below and right hits above the key layer separates the sign convention of the bend sum.
- Two full tracks tell the tie-break from the count ordering.
- A layer holding both side cells, with no centre hit, exposes the in-window priority.

Hits placed only at index 0 beside a key-layer hit at index 31 would reveal wrap-around. One hit pattern run in both modes shows that the di-strip widening moves the winner and raises its count.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_NONE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CTR  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_LO   = 2'd2;
  localparam logic [SEL_W-1:0] SEL_HI   = 2'd3;
endpackage

// File: rtl/spf_prep.sv
module spf_prep #(
  parameter int NL = 6,
  parameter int NK = 32
) (
  input  logic [NL-1:0][NK-1:0] hits_i,
  input  logic                  distrip_i,
  output logic [NL-1:0][NK-1:0] hits_o
);
  for (genvar l = 0; l < NL; l++) begin : g_l
    for (genvar i = 0; i < NK; i++) begin : g_i
      if ((i ^ 1) < NK) begin : g_pair
        assign hits_o[l][i] = hits_i[l][i] | (distrip_i & hits_i[l][i ^ 1]);
      end else begin : g_single
        assign hits_o[l][i] = hits_i[l][i];
      end
    end
  end
endmodule

// File: rtl/spf_env.sv
module spf_env
  import spf_pkg::*;
#(
  parameter int NL        = 6,
  parameter int NK        = 32,
  parameter int KEY_LAYER = 3,
  parameter int CW        = 3
) (
  input  logic [NL-1:0][NK-1:0]            hits_i,
  output logic [NK-1:0][NL-1:0][SEL_W-1:0] sel_o,
  output logic [NK-1:0][CW-1:0]            cnt_o
);
  for (genvar k = 0; k < NK; k++) begin : g_k
    for (genvar l = 0; l < NL; l++) begin : g_l
      if (l == KEY_LAYER) begin : g_key
        assign sel_o[k][l] = hits_i[l][k] ? SEL_CTR : SEL_NONE;
      end else begin : g_win
        logic lo, hi;
        if (k > 0) begin : g_lo
          assign lo = hits_i[l][k-1];
        end else begin : g_lo_edge
          assign lo = 1'b0;
        end
        if (k < NK-1) begin : g_hi
          assign hi = hits_i[l][k+1];
        end else begin : g_hi_edge
          assign hi = 1'b0;
        end
        // centre first, then lower neighbour, then upper
        assign sel_o[k][l] = hits_i[l][k] ? SEL_CTR :
                             lo           ? SEL_LO  :
                             hi           ? SEL_HI  : SEL_NONE;
      end
    end

    logic [CW-1:0] n;
    always_comb begin
      n = '0;
      for (int l = 0; l < NL; l++)
        if (sel_o[k][l] != SEL_NONE) n = n + 1'b1;
    end
    assign cnt_o[k] = n;
  end
endmodule

// File: rtl/spf_select.sv
module spf_select
  import spf_pkg::*;
#(
  parameter int NL        = 6,
  parameter int NK        = 32,
  parameter int KEY_LAYER = 3,
  parameter int CW        = 3,
  parameter int KW        = 5,
  parameter int BW        = 4
) (
  input  logic [NK-1:0][NL-1:0][SEL_W-1:0] sel_i,
  input  logic [NK-1:0][CW-1:0]            cnt_i,
  input  logic [NK-1:0]                    qual_i,
  output logic                             valid_o,
  output logic [KW-1:0]                    key_o,
  output logic [CW-1:0]                    nhit_o,
  output logic [BW-1:0]                    bend_o
);
  localparam logic signed [BW-1:0] ONE = BW'(1);

  logic                      found;
  logic [KW-1:0]             best_key;
  logic [CW-1:0]             best_cnt;
  logic [NL-1:0][SEL_W-1:0]  win_sel;
  logic signed [BW-1:0]      acc;

  // strict '>' while scanning upward keeps the lower key on a tie
  always_comb begin
    found    = 1'b0;
    best_key = '0;
    best_cnt = '0;
    for (int k = 0; k < NK; k++) begin
      if (qual_i[k] && (!found || cnt_i[k] > best_cnt)) begin
        found    = 1'b1;
        best_key = KW'(k);
        best_cnt = cnt_i[k];
      end
    end
  end

  assign win_sel = sel_i[best_key];

  // bend lookup on the winner's selected hits only
  always_comb begin
    acc = '0;
    for (int l = 0; l < NL; l++) begin
      if (l < KEY_LAYER) begin
        if (win_sel[l] == SEL_LO) acc = acc + ONE;
        if (win_sel[l] == SEL_HI) acc = acc - ONE;
      end else if (l > KEY_LAYER) begin
        if (win_sel[l] == SEL_LO) acc = acc - ONE;
        if (win_sel[l] == SEL_HI) acc = acc + ONE;
      end
    end
  end

  assign valid_o = found;
  assign key_o   = found ? best_key : '0;
  assign nhit_o  = found ? best_cnt : '0;
  assign bend_o  = found ? acc      : '0;
endmodule

// File: rtl/strip_pattern_finder.sv
module strip_pattern_finder
  import spf_pkg::*;
#(
  parameter int NL        = 6,
  parameter int NK        = 32,
  parameter int KEY_LAYER = 3,
  parameter int CW        = $clog2(NL + 1),
  parameter int KW        = $clog2(NK),
  parameter int BW        = $clog2(NL) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NL-1:0][NK-1:0] hits_i,
  input  logic [NK-1:0]         key_en_i,
  input  logic [CW-1:0]         thresh_i,
  input  logic                  distrip_i,
  output logic                  valid_o,
  output logic [KW-1:0]         key_o,
  output logic [CW-1:0]         nhit_o,
  output logic [BW-1:0]         bend_o
);
  // stage 1: mode-adjusted hits and controls
  logic [NL-1:0][NK-1:0] prep_hits, s1_hits;
  logic [NK-1:0]         s1_en;
  logic [CW-1:0]         s1_thr;

  spf_prep #(.NL(NL), .NK(NK)) u_prep (
    .hits_i   (hits_i),
    .distrip_i(distrip_i),
    .hits_o   (prep_hits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_hits <= '0;
      s1_en   <= '0;
      s1_thr  <= '0;
    end else begin
      s1_hits <= prep_hits;
      s1_en   <= key_en_i;
      s1_thr  <= (thresh_i == '0) ? CW'(1) : thresh_i;
    end
  end

  // stage 2: per-key envelope counts and qualification
  logic [NK-1:0][NL-1:0][SEL_W-1:0] env_sel, s2_sel;
  logic [NK-1:0][CW-1:0]            env_cnt, s2_cnt;
  logic [NK-1:0]                    env_qual, s2_qual;

  spf_env #(.NL(NL), .NK(NK), .KEY_LAYER(KEY_LAYER), .CW(CW)) u_env (
    .hits_i(s1_hits),
    .sel_o (env_sel),
    .cnt_o (env_cnt)
  );

  for (genvar k = 0; k < NK; k++) begin : g_qual
    assign env_qual[k] = s1_en[k] && (env_cnt[k] >= s1_thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_sel  <= '0;
      s2_cnt  <= '0;
      s2_qual <= '0;
    end else begin
      s2_sel  <= env_sel;
      s2_cnt  <= env_cnt;
      s2_qual <= env_qual;
    end
  end

  // stage 3: winner, bend lookup, output registers
  logic          win_valid;
  logic [KW-1:0] win_key;
  logic [CW-1:0] win_cnt;
  logic [BW-1:0] win_bend;

  spf_select #(
    .NL(NL), .NK(NK), .KEY_LAYER(KEY_LAYER), .CW(CW), .KW(KW), .BW(BW)
  ) u_sel (
    .sel_i  (s2_sel),
    .cnt_i  (s2_cnt),
    .qual_i (s2_qual),
    .valid_o(win_valid),
    .key_o  (win_key),
    .nhit_o (win_cnt),
    .bend_o (win_bend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      key_o   <= '0;
      nhit_o  <= '0;
      bend_o  <= '0;
    end else begin
      valid_o <= win_valid;
      key_o   <= win_key;
      nhit_o  <= win_cnt;
      bend_o  <= win_bend;
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int NL = 6,
  parameter int NK = 32,
  parameter int CW = 3,
  parameter int KW = 5,
  parameter int BW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NK-1:0] key_en_i,
  input logic [CW-1:0] thresh_i,
  input logic          valid_o,
  input logic [KW-1:0] key_o,
  input logic [CW-1:0] nhit_o,
  input logic [BW-1:0] bend_o
);
  logic [2:0][NK-1:0] en_d;
  logic [2:0][CW-1:0] thr_d;
  logic [1:0]         warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d  <= '0;
      thr_d <= '0;
      warm  <= '0;
    end else begin
      en_d  <= {en_d[1:0], key_en_i};
      thr_d <= {thr_d[1:0], thresh_i};
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  logic [CW-1:0] eff_thr;
  assign eff_thr = (thr_d[2] == '0) ? CW'(1) : thr_d[2];

  // R10
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (key_o == '0 && nhit_o == '0 && bend_o == '0));

  // R4
  p_count_thresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && warm == 2'd3) |-> (nhit_o >= eff_thr));

  // R6
  p_key_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && warm == 2'd3) |-> en_d[2][key_o]);

  // R2
  p_count_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nhit_o <= CW'(NL));

  // R8
  p_bend_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(bend_o) <= (NL - 1) && $signed(bend_o) >= -(NL - 1)));
endmodule

bind strip_pattern_finder spf_checker #(
  .NL(NL), .NK(NK), .CW(CW), .KW(KW), .BW(BW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .key_en_i(key_en_i),
  .thresh_i(thresh_i),
  .valid_o (valid_o),
  .key_o   (key_o),
  .nhit_o  (nhit_o),
  .bend_o  (bend_o)
);

// File: tb/strip_pattern_finder_bench.sv
`timescale 1ns/1ps
module strip_pattern_finder_bench;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [5:0][31:0] hits_i = '0;
  logic [31:0]      key_en_i = '1;
  logic [2:0]       thresh_i = 3'd4;
  logic             distrip_i = 1'b0;
  logic             valid_o;
  logic [4:0]       key_o;
  logic [2:0]       nhit_o;
  logic [3:0]       bend_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  strip_pattern_finder u_strip_pattern_finder (.*);

  // offsets per layer, 2 bits each: 0 centre, 1 key-1, 2 key+1
  typedef struct packed {
    logic [4:0]  k0; logic [5:0] m0; logic [11:0] o0;
    logic        t1;
    logic [4:0]  k1; logic [5:0] m1; logic [11:0] o1;
    logic        ev; logic [4:0] ek; logic [2:0] en; logic [3:0] eb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd10, 6'h3F, 12'h000, 1'b0, 5'd0,  6'h00, 12'h000, 1'b1, 5'd10, 3'd6, 4'h0}, // R2 straight
    '{5'd20, 6'h3F, 12'hA15, 1'b0, 5'd0,  6'h00, 12'h000, 1'b1, 5'd20, 3'd6, 4'h5}, // R8 tilted
    '{5'd5,  6'h0F, 12'h000, 1'b0, 5'd0,  6'h00, 12'h000, 1'b1, 5'd5,  3'd4, 4'h0}, // R4 at threshold
    '{5'd5,  6'h0B, 12'h000, 1'b0, 5'd0,  6'h00, 12'h000, 1'b0, 5'd0,  3'd0, 4'h0}, // R10 below
    '{5'd8,  6'h3F, 12'h000, 1'b1, 5'd25, 6'h3F, 12'h000, 1'b1, 5'd8,  3'd6, 4'h0}, // R5 tie
    '{5'd4,  6'h1F, 12'h000, 1'b1, 5'd28, 6'h3F, 12'h000, 1'b1, 5'd28, 3'd6, 4'h0}, // R5 count
    '{5'd0,  6'h3F, 12'h000, 1'b0, 5'd0,  6'h00, 12'h000, 1'b1, 5'd0,  3'd6, 4'h0}, // R3 low edge
    '{5'd31, 6'h3F, 12'h000, 1'b0, 5'd0,  6'h00, 12'h000, 1'b1, 5'd31, 3'd6, 4'h0}  // R3 high edge
  };

  function automatic logic [5:0][31:0] track(input logic [4:0] k, input logic [5:0] m,
                                             input logic [11:0] o);
    logic [5:0][31:0] h = '0;
    for (int l = 0; l < 6; l++) begin
      int p = int'(k);
      if (o[2*l +: 2] == 2'd1) p = p - 1;
      if (o[2*l +: 2] == 2'd2) p = p + 1;
      if (m[l] && p >= 0 && p < 32) h[l][p] = 1'b1;
    end
    return h;
  endfunction

  task automatic check(input string tag, input logic ev, input logic [4:0] ek,
                       input logic [2:0] en, input logic [3:0] eb);
    n_chk++;
    if (valid_o !== ev || key_o !== ek || nhit_o !== en || bend_o !== eb) begin
      n_bad++;
      $display("FAIL %s: got v=%0b k=%0d n=%0d b=%h exp v=%0b k=%0d n=%0d b=%h",
               tag, valid_o, key_o, nhit_o, bend_o, ev, ek, en, eb);
    end
  endtask

  task automatic run(input logic [5:0][31:0] h);
    @(negedge clk_i);
    hits_i = h;
    repeat (3) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [5:0][31:0] h;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 reset state", 1'b0, 5'd0, 3'd0, 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 latency: result absent after 2 edges, present after 3
    @(negedge clk_i);
    hits_i = track(5'd10, 6'h3F, 12'h000);
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 not before 3 edges", 1'b0, 5'd0, 3'd0, 4'h0);
    @(posedge clk_i);
    #1;
    check("R1 after 3 edges", 1'b1, 5'd10, 3'd6, 4'h0);

    for (int i = 0; i < NV; i++) begin
      h = track(VECS[i].k0, VECS[i].m0, VECS[i].o0);
      if (VECS[i].t1) h = h | track(VECS[i].k1, VECS[i].m1, VECS[i].o1);
      run(h);
      check($sformatf("R2/R5/R8 vector %0d", i),
            VECS[i].ev, VECS[i].ek, VECS[i].en, VECS[i].eb);
    end

    // R6: disable key 10 of a straight track; neighbours 9 and 11 tie at 5
    key_en_i = '1;
    key_en_i[10] = 1'b0;
    run(track(5'd10, 6'h3F, 12'h000));
    check("R6 masked key", 1'b1, 5'd9, 3'd5, 4'hF);
    key_en_i = '1;

    // R4 threshold 5 rejects a 4-layer track
    thresh_i = 3'd5;
    run(track(5'd5, 6'h0F, 12'h000));
    check("R4 thresh 5", 1'b0, 5'd0, 3'd0, 4'h0);

    // R4 threshold 0 acts as 1
    thresh_i = 3'd0;
    h = '0;
    h[3][7] = 1'b1;
    run(h);
    check("R4 thresh 0", 1'b1, 5'd7, 3'd1, 4'h0);
    thresh_i = 3'd4;

    // R7: layer 0 holds both side cells, layer 1 centre and lower
    h = track(5'd15, 6'h3E, 12'h000);
    h[0][14] = 1'b1; h[0][16] = 1'b1; h[1][14] = 1'b1;
    run(h);
    check("R7 window priority", 1'b1, 5'd15, 3'd6, 4'h1);

    // R3: no wrap from index 0 to key 31
    h = '0;
    h[3][31] = 1'b1;
    h[0][0] = 1'b1; h[1][0] = 1'b1; h[2][0] = 1'b1; h[4][0] = 1'b1; h[5][0] = 1'b1;
    run(h);
    check("R3 no wrap", 1'b1, 5'd0, 3'd5, 4'h0);

    // R9: same pattern in both modes
    h = '0;
    h[3][11] = 1'b1;
    h[0][13] = 1'b1; h[1][13] = 1'b1; h[2][13] = 1'b1; h[4][13] = 1'b1; h[5][13] = 1'b1;
    distrip_i = 1'b0;
    run(h);
    check("R9 half-strip mode", 1'b1, 5'd12, 3'd5, 4'hF);
    distrip_i = 1'b1;
    run(h);
    check("R9 di-strip mode", 1'b1, 5'd11, 3'd6, 4'hF);
    distrip_i = 1'b0;

    // R10 empty input
    run('0);
    check("R10 empty", 1'b0, 5'd0, 3'd0, 4'h0);

    // R1 asynchronous reset clears a held result
    run(track(5'd10, 6'h3F, 12'h000));
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async reset", 1'b0, 5'd0, 3'd0, 4'h0);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule